// File: doc/BRIEF.md
# Two-Port Mailbox Interrupt Flags

This block provides doorbell signalling between the two sides of a shared two-port memory. The two highest words of the address space act as mailboxes, one for each direction. When one side writes its outgoing mailbox word, a flag is raised toward the other side. That flag appears on the other side's active-low interrupt output. When the receiving side reads that same word, its flag is cleared. This lets software on each side post a message and signal it without a separate control register.

The block sees only the control and address lines of each side: chip select, write enable, output enable, address and an active-low busy input from the arbitration logic. It holds the two flag registers. The storage array and the arbiter live elsewhere. Inputs are sampled on the rising clock edge, and a flag change shows on the interrupt pin right after that edge.

Top module: `dpram_mailbox_irq`

## Requirements
- R1: While `rst_n` is low at a clock edge, both flags clear, so after that edge `l_irq_n` and `r_irq_n` are both 1.
- R2: A left write (`l_cs_n`=0, `l_we_n`=0) to the top address (all address bits 1, 0x1FFF by default) drives `r_irq_n` to 0 after that edge.
- R3: A right read (`r_cs_n`=0, `r_we_n`=1, `r_oe_n`=0) of the top address drives `r_irq_n` back to 1 after that edge.
- R4: A right write to the top address minus one (0x1FFE by default) drives `l_irq_n` to 0 after that edge.
- R5: A left read of the top address minus one drives `l_irq_n` back to 1 after that edge.
- R6: An access from a side whose busy input is 0 neither sets nor clears any flag.
- R7: If a set and a clear of the same flag happen at the same edge, the flag ends up set.
- R8: No other access changes either flag. This covers other addresses, reads with `oe_n`=1, cycles with `cs_n`=1, a read of a side's own outgoing mailbox, and a write to its incoming mailbox.
- R9: The two flags are independent: an action on one flag leaves the other flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| l_cs_n | input | 1 | Left chip select, active low |
| l_we_n | input | 1 | Left write enable, 0 = write, 1 = read |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | ADDR_W | Left word address |
| l_busy_n | input | 1 | Left busy from arbiter, 0 = access blocked |
| r_cs_n | input | 1 | Right chip select, active low |
| r_we_n | input | 1 | Right write enable, 0 = write, 1 = read |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | ADDR_W | Right word address |
| r_busy_n | input | 1 | Right busy from arbiter, 0 = access blocked |
| l_irq_n | output | 1 | Interrupt to the left side, active low |
| r_irq_n | output | 1 | Interrupt to the right side, active low |

## Verification
The assertions check four things on every clock. A flag never changes without a decoded set or clear. A set always leaves its flag raised, even when a clear comes at the same edge. A side that is busy never moves a flag. Reset always releases both interrupts. The bench scenarios are needed to show the full address decode: which exact address, side and combination of control lines raises or clears each flag, and that near-miss addresses and wrong-side accesses are ignored. They also show the complete post, acknowledge and re-post sequence as seen from the output pins.

// File: rtl/mbx_pkg.sv
// Package: shared side encoding and mailbox address helpers.
// Assumes the two mailboxes are the two highest words of the address space.
package mbx_pkg;

    typedef enum logic {
        SIDE_LEFT  = 1'b0,
        SIDE_RIGHT = 1'b1
    } side_e;

    // Decoded effect of one side's access on the flag registers.
    typedef struct packed {
        logic set_peer;   // raise the opposite side's flag
        logic clr_own;    // drop this side's own flag
    } mbx_req_t;

    // Highest word: left posts here, right receives here.
    function automatic logic [31:0] mbx_top(input int unsigned aw);
        return (32'h1 << aw) - 32'h1;
    endfunction

    // Word below it: right posts here, left receives here.
    function automatic logic [31:0] mbx_next(input int unsigned aw);
        return (32'h1 << aw) - 32'h2;
    endfunction

endpackage

// File: rtl/mbx_port_decode.sv
// Module: mbx_port_decode
// Decodes one side's control lines and address into a mailbox request.
// The side parameter chooses which of the two top words is outgoing.
// Assumes active-low strobes; a low busy input suppresses every request.
module mbx_port_decode
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W = 13,
    parameter side_e       SIDE   = SIDE_LEFT
) (
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              busy_n,
    input  logic [ADDR_W-1:0] addr,
    output mbx_req_t          req
);
    localparam logic [31:0] TOP_W  = mbx_top(ADDR_W);
    localparam logic [31:0] NEXT_W = mbx_next(ADDR_W);
    localparam logic [ADDR_W-1:0] TOP_A  = TOP_W[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] NEXT_A = NEXT_W[ADDR_W-1:0];

    logic [ADDR_W-1:0] out_addr;
    logic [ADDR_W-1:0] in_addr;

    // Pick outgoing and incoming mailbox words for this side.
    generate
        if (SIDE == SIDE_LEFT) begin : g_left
            assign out_addr = TOP_A;
            assign in_addr  = NEXT_A;
        end else begin : g_right
            assign out_addr = NEXT_A;
            assign in_addr  = TOP_A;
        end
    endgenerate

    logic wr_cyc;
    logic rd_cyc;

    // Qualify write and read cycles, gated by the arbiter's busy.
    always_comb begin
        wr_cyc = !cs_n && !we_n && busy_n;
        rd_cyc = !cs_n &&  we_n && !oe_n && busy_n;
        req.set_peer = wr_cyc && (addr == out_addr);
        req.clr_own  = rd_cyc && (addr == in_addr);
    end

endmodule

// File: rtl/mbx_flag.sv
// Module: mbx_flag
// One interrupt flag register; a set beats a clear at the same edge.
// Assumes a synchronous active-low reset that leaves the flag clear.
module mbx_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_n
);
    logic flag_q;

    // Update the flag from set and clear, set taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_q <= 1'b0;
        else if (set_i)  flag_q <= 1'b1;
        else if (clr_i)  flag_q <= 1'b0;
    end

    assign irq_n = !flag_q;

    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> !irq_n)
        else $error("set did not raise flag");

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> irq_n)
        else $error("clear did not drop flag");

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(irq_n))
        else $error("flag moved without request");

endmodule

// File: rtl/dpram_mailbox_irq.sv
// Module: dpram_mailbox_irq
// Mailbox interrupt logic for a two-port memory: a write to one side's
// outgoing top word flags the other side, whose read of it clears the flag.
// Assumes both sides are synchronous to clk; array and arbiter are external.
module dpram_mailbox_irq
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_cs_n,
    input  logic              l_we_n,
    input  logic              l_oe_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_busy_n,
    input  logic              r_cs_n,
    input  logic              r_we_n,
    input  logic              r_oe_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_busy_n,
    output logic              l_irq_n,
    output logic              r_irq_n
);
    localparam logic [31:0] TOP_W = mbx_top(ADDR_W);
    localparam logic [ADDR_W-1:0] TOP_A = TOP_W[ADDR_W-1:0];

    mbx_req_t l_req;
    mbx_req_t r_req;

    mbx_port_decode #(.ADDR_W(ADDR_W), .SIDE(SIDE_LEFT)) u_dec_l (
        .cs_n   (l_cs_n),
        .we_n   (l_we_n),
        .oe_n   (l_oe_n),
        .busy_n (l_busy_n),
        .addr   (l_addr),
        .req    (l_req)
    );

    mbx_port_decode #(.ADDR_W(ADDR_W), .SIDE(SIDE_RIGHT)) u_dec_r (
        .cs_n   (r_cs_n),
        .we_n   (r_we_n),
        .oe_n   (r_oe_n),
        .busy_n (r_busy_n),
        .addr   (r_addr),
        .req    (r_req)
    );

    // Flag seen by the left side: set by right, cleared by left.
    mbx_flag u_flag_l (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (r_req.set_peer),
        .clr_i (l_req.clr_own),
        .irq_n (l_irq_n)
    );

    // Flag seen by the right side: set by left, cleared by right.
    mbx_flag u_flag_r (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (l_req.set_peer),
        .clr_i (r_req.clr_own),
        .irq_n (r_irq_n)
    );

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (l_irq_n && r_irq_n))
        else $error("reset left an interrupt active");

    p_left_post_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_cs_n && !l_we_n && l_busy_n && l_addr == TOP_A) |=> !r_irq_n)
        else $error("left post did not flag right");

    p_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_busy_n && !r_busy_n) |=> ($stable(l_irq_n) && $stable(r_irq_n)))
        else $error("flag moved while both sides busy");

endmodule

// File: tb/dpram_mailbox_irq_test.sv
// Directed bench for dpram_mailbox_irq: one task per scenario.
module dpram_mailbox_irq_test;
    localparam int unsigned AW = 13;
    localparam logic [AW-1:0] TOP  = 13'h1FFF;
    localparam logic [AW-1:0] NEXT = 13'h1FFE;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_cs_n = 1, l_we_n = 1, l_oe_n = 1, l_busy_n = 1;
    logic r_cs_n = 1, r_we_n = 1, r_oe_n = 1, r_busy_n = 1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic l_irq_n, r_irq_n;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dpram_mailbox_irq #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .l_cs_n(l_cs_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n),
        .l_addr(l_addr), .l_busy_n(l_busy_n),
        .r_cs_n(r_cs_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n),
        .r_addr(r_addr), .r_busy_n(r_busy_n),
        .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic idle();
        l_cs_n = 1; l_we_n = 1; l_oe_n = 1; l_busy_n = 1;
        r_cs_n = 1; r_we_n = 1; r_oe_n = 1; r_busy_n = 1;
        l_addr = '0; r_addr = '0;
    endtask

    // Apply the current inputs over one rising edge, then go idle.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic l_write(input logic [AW-1:0] a);
        l_cs_n = 0; l_we_n = 0; l_oe_n = 1; l_addr = a;
    endtask
    task automatic l_read(input logic [AW-1:0] a);
        l_cs_n = 0; l_we_n = 1; l_oe_n = 0; l_addr = a;
    endtask
    task automatic r_write(input logic [AW-1:0] a);
        r_cs_n = 0; r_we_n = 0; r_oe_n = 1; r_addr = a;
    endtask
    task automatic r_read(input logic [AW-1:0] a);
        r_cs_n = 0; r_we_n = 1; r_oe_n = 0; r_addr = a;
    endtask

    task automatic t_reset();
        rst_n = 0; idle();
        step(); step();
        check("R1 left irq after reset", l_irq_n, 1'b1);
        check("R1 right irq after reset", r_irq_n, 1'b1);
        rst_n = 1; step();
    endtask

    task automatic t_left_to_right();
        l_write(TOP); step();
        check("R2 right irq after left post", r_irq_n, 1'b0);
        check("R9 left irq untouched", l_irq_n, 1'b1);
        step();
        check("R2 right irq holds", r_irq_n, 1'b0);
        l_read(TOP); step();
        check("R8 left read of own outbox keeps right irq", r_irq_n, 1'b0);
        r_read(TOP); step();
        check("R3 right irq after right read", r_irq_n, 1'b1);
    endtask

    task automatic t_right_to_left();
        r_write(NEXT); step();
        check("R4 left irq after right post", l_irq_n, 1'b0);
        check("R9 right irq untouched", r_irq_n, 1'b1);
        r_read(NEXT); step();
        check("R8 right read of own outbox keeps left irq", l_irq_n, 1'b0);
        l_read(NEXT); step();
        check("R5 left irq after left read", l_irq_n, 1'b1);
    endtask

    task automatic t_busy();
        l_write(TOP); l_busy_n = 0; step();
        check("R6 busy left write ignored", r_irq_n, 1'b1);
        r_write(NEXT); r_busy_n = 0; step();
        check("R6 busy right write ignored", l_irq_n, 1'b1);
        l_write(TOP); step();
        r_read(TOP); r_busy_n = 0; step();
        check("R6 busy right read keeps flag", r_irq_n, 1'b0);
        r_read(TOP); step();
        check("R3 clear after busy released", r_irq_n, 1'b1);
    endtask

    task automatic t_collision();
        l_write(TOP); step();
        l_write(TOP); r_read(TOP); step();
        check("R7 set beats clear on right flag", r_irq_n, 1'b0);
        r_write(NEXT); step();
        r_write(NEXT); l_read(NEXT); step();
        check("R7 set beats clear on left flag", l_irq_n, 1'b0);
        r_read(TOP); l_read(NEXT); step();
        check("R3 right cleared", r_irq_n, 1'b1);
        check("R5 left cleared", l_irq_n, 1'b1);
    endtask

    task automatic t_ignored();
        l_write(13'h1FFD); r_write(13'h0000); step();
        check("R8 other address no right set", r_irq_n, 1'b1);
        check("R8 other address no left set", l_irq_n, 1'b1);
        l_write(TOP); l_cs_n = 1; step();
        check("R8 deselected write ignored", r_irq_n, 1'b1);
        l_write(NEXT); r_write(TOP); step();
        check("R8 write to inbox sets nothing (left)", l_irq_n, 1'b1);
        check("R8 write to inbox sets nothing (right)", r_irq_n, 1'b1);
        l_write(TOP); step();
        r_read(TOP); r_oe_n = 1; step();
        check("R8 read without oe keeps flag", r_irq_n, 1'b0);
        r_read(13'h0FFF); step();
        check("R8 read of other address keeps flag", r_irq_n, 1'b0);
        rst_n = 0; step();
        check("R1 reset clears pending flag", r_irq_n, 1'b1);
        rst_n = 1; step();
    endtask

    initial begin
        fork
            begin
                @(negedge clk);
                t_reset();
                t_left_to_right();
                t_right_to_left();
                t_busy();
                t_collision();
                t_ignored();
            end
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule